// File: doc/BRIEF.md
# State-Aware Pass Bias Selector

During a read of one wordline in a flash block, every other wordline on the same bitlines must be biased so that its cells conduct. The pass bias weakly programs those cells, and cells that are erased or only half programmed suffer most because the gap between their threshold and the bias is widest. This block assigns a gate bias code to every wordline of the block. The addressed wordline gets the sense (read reference) code. Each of the other wordlines gets one of three pass codes, chosen from its programming state as reported by the program sequencer: a low level for erased rows, a middle level for rows that hold only their first programming step, and the normal level for fully programmed rows.

The selection is a pure decode of the requested index and the state vector, captured into a register on each clock in which the read enable is high. When no read is requested the register returns every lane to the idle code, and the state vector is ignored. A request whose index lies beyond the last wordline of the block is dropped: the lanes stay idle and the read-active flag stays low. Only codes are produced here. The analog levels behind each code are generated elsewhere, and the choice of code adds nothing to program time.

Top module: `pvsel_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every lane of `bias_o` is 2'b00 and `rd_active_o` is 0.
- R2: In the cycle after a clock edge at which `rd_en_i` is low, every lane of `bias_o` is 2'b00 and `rd_active_o` is 0, whatever `sel_wl_i` and `wl_state_i` hold.
- R3: In the cycle after an edge with `rd_en_i` high and `sel_wl_i` below NUM_WL, lane `sel_wl_i` of `bias_o` holds the sense code 2'b00.
- R4: In that cycle each other lane whose state field (bits 2i+1:2i of `wl_state_i`) was 2'b00 (erased) holds 2'b01 (low pass level).
- R5: Each other lane whose state field was 2'b01 (first step only) holds 2'b10 (middle pass level).
- R6: Each other lane whose state field was 2'b10 (fully programmed) holds 2'b11 (normal pass level).
- R7: A state field of 2'b11 (not defined by the sequencer) on an unselected lane gives 2'b11, the normal pass level.
- R8: Whenever `rd_active_o` is high, exactly one lane of `bias_o` holds 2'b00.
- R9: An edge with `rd_en_i` high and `sel_wl_i` at or above NUM_WL leaves, in the next cycle, every lane at 2'b00 and `rd_active_o` at 0.
- R10: `rd_active_o` is high in the cycle after each edge with `rd_en_i` high and an in-range `sel_wl_i`; codes reflect the inputs at that edge, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| rd_en_i | input | 1 | Read request, sampled at each rising edge |
| sel_wl_i | input | IDX_W ($clog2(NUM_WL), 4 by default) | Index of the wordline being sensed |
| wl_state_i | input | 2*NUM_WL (24 by default) | Per-wordline state, field i at bits 2i+1:2i: 00 erased, 01 first step, 10 full, 11 undefined |
| bias_o | output | 2*NUM_WL (24 by default) | Per-wordline bias code, lane i at bits 2i+1:2i: 00 sense/idle, 01 low pass, 10 middle pass, 11 normal pass |
| rd_active_o | output | 1 | High while `bias_o` carries an accepted read |

## Verification
The hardest case to reach from the ports is a read whose index is one of the codes the index field can carry but the block does not have (12 to 15 with the default twelve wordlines), arriving back to back with valid reads, where a wrongly decoded lane could leave zero or two sense codes. The stimulus runs directed reads at both ends of the index range and just beyond it, then a long run of random indices over the whole field mixed with random state patterns that include the undefined code, so every state lands on every lane next to both a valid and a dropped request.

// File: rtl/pvsel_pkg.sv
package pvsel_pkg;

  typedef enum logic [1:0] {
    ST_ERASED  = 2'b00,
    ST_PARTIAL = 2'b01,
    ST_FULL    = 2'b10,
    ST_UNDEF   = 2'b11
  } wl_state_e;

  typedef enum logic [1:0] {
    BC_SENSE      = 2'b00,
    BC_PASS_LOW   = 2'b01,
    BC_PASS_MID   = 2'b10,
    BC_PASS_HIGH  = 2'b11
  } bias_code_e;

  localparam logic [1:0] BC_IDLE = 2'b00;

  // Pass level for an unselected row: the lower its threshold, the lower
  // the bias, so the gap that drives disturb stays small. Unknown states
  // take the normal level, which is sure to make the cells conduct.
  function automatic logic [1:0] pass_for_state(input logic [1:0] st);
    logic [1:0] code;
    case (wl_state_e'(st))
      ST_ERASED:  code = BC_PASS_LOW;
      ST_PARTIAL: code = BC_PASS_MID;
      default:    code = BC_PASS_HIGH;
    endcase
    return code;
  endfunction

  // Code for one lane given whether it is the sensed row.
  function automatic logic [1:0] lane_code(input logic is_sel, input logic [1:0] st);
    return is_sel ? BC_SENSE : pass_for_state(st);
  endfunction

endpackage

// File: rtl/pvsel_decode.sv
module pvsel_decode #(
  parameter int NUM_WL = 12,
  parameter int IDX_W  = $clog2(NUM_WL)
) (
  input  logic              en_i,
  input  logic [IDX_W-1:0]  sel_i,
  output logic              ok_o,
  output logic [NUM_WL-1:0] hot_o
);
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_WL);

  assign ok_o = en_i && ({1'b0, sel_i} < LIMIT);

  for (genvar g = 0; g < NUM_WL; g++) begin : g_hot
    assign hot_o[g] = ok_o && (sel_i == IDX_W'(g));
  end
endmodule

// File: rtl/pvsel_lane.sv
module pvsel_lane (
  input  logic       is_sel_i,
  input  logic [1:0] state_i,
  output logic [1:0] code_o
);
  import pvsel_pkg::*;
  always_comb code_o = lane_code(is_sel_i, state_i);
endmodule

// File: rtl/pvsel_top.sv
module pvsel_top #(
  parameter int NUM_WL = 12,
  parameter int IDX_W  = $clog2(NUM_WL)
) (
  input  logic                  clk_i,
  input  logic                  rst_n_i,
  input  logic                  rd_en_i,
  input  logic [IDX_W-1:0]      sel_wl_i,
  input  logic [2*NUM_WL-1:0]   wl_state_i,
  output logic [2*NUM_WL-1:0]   bias_o,
  output logic                  rd_active_o
);
  import pvsel_pkg::*;

  localparam int VEC_W = 2 * NUM_WL;

  // Named internal events for the checker.
  logic              req_ok;
  logic [NUM_WL-1:0] sel_hot;
  logic [VEC_W-1:0]  lane_codes;
  logic [VEC_W-1:0]  bias_next;

  pvsel_decode #(.NUM_WL(NUM_WL), .IDX_W(IDX_W)) u_decode (
    .en_i  (rd_en_i),
    .sel_i (sel_wl_i),
    .ok_o  (req_ok),
    .hot_o (sel_hot)
  );

  for (genvar g = 0; g < NUM_WL; g++) begin : g_lane
    pvsel_lane u_lane (
      .is_sel_i (sel_hot[g]),
      .state_i  (wl_state_i[2*g +: 2]),
      .code_o   (lane_codes[2*g +: 2])
    );
  end

  // Idle or dropped request: every lane back to the idle code and the
  // state vector is not looked at.
  assign bias_next = req_ok ? lane_codes : {NUM_WL{BC_IDLE}};

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      bias_o      <= {NUM_WL{BC_IDLE}};
      rd_active_o <= 1'b0;
    end else begin
      bias_o      <= bias_next;
      rd_active_o <= req_ok;
    end
  end
endmodule

// File: rtl/pvsel_top_chk.sv
module pvsel_top_chk #(
  parameter int NUM_WL = 12,
  parameter int IDX_W  = $clog2(NUM_WL)
) (
  input logic                clk_i,
  input logic                rst_n_i,
  input logic                rd_en_i,
  input logic [IDX_W-1:0]    sel_wl_i,
  input logic [2*NUM_WL-1:0] wl_state_i,
  input logic [2*NUM_WL-1:0] bias_o,
  input logic                rd_active_o,
  input logic                req_ok,
  input logic [NUM_WL-1:0]   sel_hot
);
  logic in_range;
  int   zero_lanes;

  assign in_range = (int'(sel_wl_i) < NUM_WL);

  always_comb begin
    zero_lanes = 0;
    for (int i = 0; i < NUM_WL; i++)
      if (bias_o[2*i +: 2] == 2'b00) zero_lanes++;
  end

  a_r2_idle_lanes: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !rd_en_i |=> (bias_o == '0) && !rd_active_o);

  a_r8_single_sense: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    rd_active_o |-> (zero_lanes == 1));

  a_r9_drop_far_index: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (rd_en_i && !in_range) |=> (bias_o == '0) && !rd_active_o);

  a_r10_active_next: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (rd_en_i && in_range) |=> rd_active_o);

  for (genvar g = 0; g < NUM_WL; g++) begin : g_lane_chk
    a_r3_sense_lane: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      sel_hot[g] |=> (bias_o[2*g +: 2] == 2'b00));
    a_r4_low_pass: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (req_ok && !sel_hot[g] && wl_state_i[2*g +: 2] == 2'b00) |=> (bias_o[2*g +: 2] == 2'b01));
    a_r5_mid_pass: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (req_ok && !sel_hot[g] && wl_state_i[2*g +: 2] == 2'b01) |=> (bias_o[2*g +: 2] == 2'b10));
    a_r6_high_pass: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (req_ok && !sel_hot[g] && wl_state_i[2*g +: 2] == 2'b10) |=> (bias_o[2*g +: 2] == 2'b11));
    a_r7_undef_state: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (req_ok && !sel_hot[g] && wl_state_i[2*g +: 2] == 2'b11) |=> (bias_o[2*g +: 2] == 2'b11));
  end

  always @(posedge clk_i) begin
    if (rst_n_i) a_r1_hot_onehot: assert ($onehot0(sel_hot));
  end
endmodule

bind pvsel_top pvsel_top_chk #(.NUM_WL(NUM_WL), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/test_pvsel_top.sv
`timescale 1ns/1ps
module test_pvsel_top;
  localparam int NUM_WL = 12;
  localparam int IDX_W  = $clog2(NUM_WL);
  localparam int VEC_W  = 2 * NUM_WL;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             rd_en;
  logic [IDX_W-1:0] sel_wl;
  logic [VEC_W-1:0] wl_state;
  logic [VEC_W-1:0] bias;
  logic             rd_active;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pvsel_top i_pvsel_top (
    .clk_i(clk), .rst_n_i(rst_n), .rd_en_i(rd_en), .sel_wl_i(sel_wl),
    .wl_state_i(wl_state), .bias_o(bias), .rd_active_o(rd_active)
  );

  // Reference: what each lane should carry, written from the requirement list.
  function automatic logic [VEC_W-1:0] ref_bias(bit rd, int sel, logic [VEC_W-1:0] st);
    logic [VEC_W-1:0] v = '0;
    if (!rd || sel >= NUM_WL) return v;
    for (int i = 0; i < NUM_WL; i++) begin
      int s = int'(st[2*i +: 2]);
      int c;
      if (i == sel) c = 0;
      else if (s == 0) c = 1;
      else if (s == 1) c = 2;
      else c = 3;
      v[2*i +: 2] = 2'(c);
    end
    return v;
  endfunction

  function automatic int count_zero(logic [VEC_W-1:0] v);
    int n = 0;
    for (int i = 0; i < NUM_WL; i++) if (v[2*i +: 2] == 2'b00) n++;
    return n;
  endfunction

  task automatic check(string req, logic [VEC_W-1:0] exp_b, bit exp_a);
    compared++;
    if (bias !== exp_b || rd_active !== exp_a) begin
      mismatched++;
      $display("FAIL %s: bias=%h active=%0b expected bias=%h active=%0b",
               req, bias, rd_active, exp_b, exp_a);
    end
    if (rd_active === 1'b1) begin
      compared++;
      if (count_zero(bias) != 1) begin
        mismatched++;
        $display("FAIL R8: sense lanes=%0d expected 1", count_zero(bias));
      end
    end
  endtask

  // Apply inputs at a falling edge, compare one clock later (one register).
  task automatic step(string req, bit rd, int sel, logic [VEC_W-1:0] st);
    logic [VEC_W-1:0] e;
    rd_en = rd; sel_wl = IDX_W'(sel); wl_state = st;
    e = ref_bias(rd, sel, st);
    @(negedge clk);
    check(req, e, rd && sel < NUM_WL);
  endtask

  function automatic logic [VEC_W-1:0] fill(logic [1:0] s);
    return {NUM_WL{s}};
  endfunction

  initial begin
    rst_n = 1'b0; rd_en = 1'b1; sel_wl = '0; wl_state = fill(2'b10);
    repeat (3) @(negedge clk);
    check("R1", '0, 1'b0);             // under reset, inputs asking for a read
    rd_en = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", '0, 1'b0);
    // R2: idle with busy-looking inputs
    step("R2", 0, 3, fill(2'b01));
    step("R2", 0, 0, 24'hA5C3F0);
    // R3/R4: lowest index, all erased
    step("R3_R4", 1, 0, fill(2'b00));
    // R5: top index, first step only
    step("R5", 1, NUM_WL-1, fill(2'b01));
    // R6: middle index, fully programmed
    step("R6", 1, 5, fill(2'b10));
    // R7: undefined state everywhere
    step("R7", 1, 7, fill(2'b11));
    // mixed pattern
    step("R4_R5_R6_R7", 1, 3, 24'h1B_E4_72);
    // R9: just past the end and the top code
    step("R9", 1, NUM_WL, fill(2'b10));
    step("R9", 1, (1 << IDX_W) - 1, fill(2'b00));
    // R10: back to back over every index, then back to idle
    for (int k = 0; k < NUM_WL; k++) step("R10", 1, k, 24'h6C_93_2D ^ VEC_W'(k * 24'h0F1F));
    step("R2", 0, 2, fill(2'b00));
    // R8: random sweep over the whole index field
    for (int k = 0; k < 400; k++)
      step("R8", ($urandom % 4) != 0, int'($urandom % (1 << IDX_W)), VEC_W'($urandom));
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #20000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule